// File: doc/BRIEF.md
# Calendar Clock with Alarm

The block keeps time of day and date in seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `sec_tick` pulse from an outside seconds source advances the time. The tick is accepted only while the three-bit oscillator control field holds the run code. The time is kept internally in binary. The visible fields are encoded at the output in BCD or plain binary, and in 24-hour or 12-hour form with a PM flag. Two mode inputs choose the encoding, and a change to either takes effect at once.

An accepted tick advances the internal time. When `set_mode` is low, the tick also opens an update window, and `uip` is high for the whole window. At the end of the window, the visible fields are refreshed from the internal time and the time is compared against the three alarm bytes. The update and alarm flags are then set. Software loads each field through a simple write strobe; the written byte is decoded under the current modes. The flags are cleared with a clear strobe.

Top module: `cal_clock`

## Requirements
- R1: After reset the fields show 00:00:00, day of week 1, date 1, month 1, year 00 (BCD, 24-hour), `uip` is low and all three flags are low.
- R2: A tick is ignored unless `osc_ctl` equals 3'b010. An ignored tick leaves the time unchanged and `uip` low.
- R3: With `set_mode` low, an accepted tick sampled at edge k drives `uip` high from edge k for UPD_DELAY cycles. At edge k+UPD_DELAY, `uip` falls, the visible fields take the advanced time, and the flags are updated.
- R4: With `set_mode` high, a tick advances the internal time but opens no update window. The visible fields and the flags stay unchanged. The advanced time shows at the next update or write.
- R5: With `data_bin` low, every field is BCD (tens digit in bits 7:4, units in 3:0). With `data_bin` high, every field is plain binary. A change re-encodes the fields without a tick.
- R6: With `hr24` low, the hour field holds 1 to 12 in bits 6:0 and bit 7 is the PM flag. Midnight is 12 with bit 7 clear, and noon is 12 with bit 7 set. With `hr24` high, the hour is 0 to 23 and bit 7 is 0.
- R7: Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the date. Day of week counts 1 to 7 and wraps to 1. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 00.
- R8: April, June, September and November have 30 days and the other months other than February have 31. February has 29 days when BASE_YEAR+year is divisible by 4, except years divisible by 100 but not by 400, and 28 days otherwise.
- R9: At the end of an update, `alarm_en` high and all three alarm bytes matching set `alarm_flag` and `irq_flag`. An alarm byte with bits 7:6 both 1 matches any value. Any other alarm byte is decoded under the current modes and compared with the field.
- R10: Every update sets `upd_flag`. It sets `irq_flag` only when `upd_irq_en` is high or the alarm fires.
- R11: `clr_flags` clears all three flags on the next edge. A flag set at the end of an update in the same cycle wins over the clear.
- R12: `wr_en` writes `wr_data`, decoded under the current modes, into the field selected by `wr_field` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year). The new value shows two edges after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| osc_ctl | input | 3 | Oscillator control; 3'b010 runs the clock |
| set_mode | input | 1 | Hold visible fields; no update window |
| data_bin | input | 1 | 1 = binary fields, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| wr_en | input | 1 | Field write strobe |
| wr_field | input | 3 | Field select for the write |
| wr_data | input | 8 | Encoded field value to write |
| alarm_en | input | 1 | Alarm interrupt enable |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| al_sec | input | 8 | Seconds alarm byte |
| al_min | input | 8 | Minutes alarm byte |
| al_hr | input | 8 | Hours alarm byte |
| clr_flags | input | 1 | Clear all flags |
| uip | output | 1 | Update in progress |
| sec_out | output | 8 | Encoded seconds |
| min_out | output | 8 | Encoded minutes |
| hr_out | output | 8 | Encoded hours |
| wday_out | output | 8 | Encoded day of week |
| mday_out | output | 8 | Encoded day of month |
| mon_out | output | 8 | Encoded month |
| year_out | output | 8 | Encoded two-digit year |
| irq_flag | output | 1 | Interrupt request flag |
| alarm_flag | output | 1 | Alarm flag |
| upd_flag | output | 1 | Update-ended flag |

## Verification
The assertions assume several things about the inputs. Ticks arrive no more often than once per update window. A tick never coincides with a write. Written bytes are valid encodings under the modes active at the time of the write. The bench keeps to these rules as follows. It waits out the full window after every tick. It issues writes only while the block is idle. It builds every written byte and every alarm byte from in-range values, using its own encoder for the current modes. The random part draws valid calendar dates for the chosen month and year, so the day of month never exceeds the month length.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [6:0] wday;
    logic [6:0] mday;
    logic [6:0] mon;
    logic [6:0] year;
  } cal_time_t;

  localparam cal_time_t CAL_RESET_TIME = '{sec: 7'd0, min: 7'd0, hr: 7'd0,
                                           wday: 7'd1, mday: 7'd1, mon: 7'd1,
                                           year: 7'd0};

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HR = 3'd2, F_WDAY = 3'd3,
    F_MDAY = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } cal_field_e;

  // Binary value to output byte (BCD when bin is low).
  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    int t, o;
    t = int'(v) / 10;
    o = int'(v) % 10;
    return bin ? {1'b0, v} : {4'(t), 4'(o)};
  endfunction

  // Output byte to binary value.
  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    int v;
    v = bin ? int'(b[6:0]) : int'(b[7:4]) * 10 + int'(b[3:0]);
    return 7'(v);
  endfunction

  function automatic logic [7:0] enc_hour(input logic [6:0] hr, input logic bin,
                                          input logic h24);
    int h;
    logic [7:0] e;
    if (h24) return enc_val(hr, bin);
    h = int'(hr) % 12;
    if (h == 0) h = 12;
    e = enc_val(7'(h), bin);
    return {(hr >= 7'd12), e[6:0]};
  endfunction

  function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic h24);
    int h;
    if (h24) return dec_val(b, bin);
    h = int'(dec_val({1'b0, b[6:0]}, bin));
    if (h == 12) h = 0;
    if (b[7]) h = h + 12;
    return 7'(h);
  endfunction

  function automatic logic alarm_field_ok(input logic [7:0] al, input logic [6:0] v,
                                          input logic [6:0] al_dec);
    return (al[7:6] == 2'b11) || (al_dec == v);
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mon,
                                               input logic [6:0] year,
                                               input int base);
    int full;
    logic leap;
    full = base + int'(year);
    leap = ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
    case (mon)
      7'd2:                        return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction

  function automatic cal_time_t next_second(input cal_time_t t, input int base);
    cal_time_t n;
    n = t;
    if (t.sec != 7'd59) begin
      n.sec = t.sec + 7'd1;
    end else begin
      n.sec = 7'd0;
      if (t.min != 7'd59) begin
        n.min = t.min + 7'd1;
      end else begin
        n.min = 7'd0;
        if (t.hr != 7'd23) begin
          n.hr = t.hr + 7'd1;
        end else begin
          n.hr   = 7'd0;
          n.wday = (t.wday >= 7'd7) ? 7'd1 : t.wday + 7'd1;
          if (t.mday < days_in_month(t.mon, t.year, base)) begin
            n.mday = t.mday + 7'd1;
          end else begin
            n.mday = 7'd1;
            if (t.mon < 7'd12) begin
              n.mon = t.mon + 7'd1;
            end else begin
              n.mon  = 7'd1;
              n.year = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  input  logic       data_bin,
  input  logic       hr24,
  output cal_time_t  cur
);

  logic [6:0] wr_plain;
  logic [6:0] wr_hour;

  assign wr_plain = dec_val(wr_data, data_bin);
  assign wr_hour  = dec_hour(wr_data, data_bin, hr24);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= CAL_RESET_TIME;
    end else if (wr_en) begin
      case (cal_field_e'(wr_field))
        F_SEC:   cur.sec  <= wr_plain;
        F_MIN:   cur.min  <= wr_plain;
        F_HR:    cur.hr   <= wr_hour;
        F_WDAY:  cur.wday <= wr_plain;
        F_MDAY:  cur.mday <= wr_plain;
        F_MON:   cur.mon  <= wr_plain;
        F_YEAR:  cur.year <= wr_plain;
        default: ;
      endcase
    end else if (adv) begin
      cur <= next_second(cur, BASE_YEAR);
    end
  end

endmodule

// File: rtl/cal_update_seq.sv
module cal_update_seq #(
  parameter int UPD_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic uip,
  output logic done
);

  localparam int CW = (UPD_DELAY > 1) ? $clog2(UPD_DELAY) : 1;

  logic [CW-1:0] cnt;

  assign done = uip && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip <= 1'b0;
      cnt <= '0;
    end else if (start && !uip) begin
      uip <= 1'b1;
      cnt <= CW'(UPD_DELAY - 1);
    end else if (done) begin
      uip <= 1'b0;
    end else if (uip) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_pkg::*;
(
  input  cal_time_t  now,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hr,
  input  logic       data_bin,
  input  logic       hr24,
  output logic       hit
);

  logic ok_sec, ok_min, ok_hr;

  assign ok_sec = alarm_field_ok(al_sec, now.sec, dec_val(al_sec, data_bin));
  assign ok_min = alarm_field_ok(al_min, now.min, dec_val(al_min, data_bin));
  assign ok_hr  = alarm_field_ok(al_hr, now.hr, dec_hour(al_hr, data_bin, hr24));
  assign hit    = ok_sec && ok_min && ok_hr;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int       UPD_DELAY = 8,
  parameter int       BASE_YEAR = 2000,
  parameter bit [2:0] OSC_RUN   = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_mode,
  input  logic       data_bin,
  input  logic       hr24,
  input  logic       wr_en,
  input  logic [2:0] wr_field,
  input  logic [7:0] wr_data,
  input  logic       alarm_en,
  input  logic       upd_irq_en,
  input  logic [7:0] al_sec,
  input  logic [7:0] al_min,
  input  logic [7:0] al_hr,
  input  logic       clr_flags,
  output logic       uip,
  output logic [7:0] sec_out,
  output logic [7:0] min_out,
  output logic [7:0] hr_out,
  output logic [7:0] wday_out,
  output logic [7:0] mday_out,
  output logic [7:0] mon_out,
  output logic [7:0] year_out,
  output logic       irq_flag,
  output logic       alarm_flag,
  output logic       upd_flag
);

  // Named internal events
  logic      tick_run;
  logic      upd_start;
  logic      upd_done;
  logic      alarm_hit;
  logic      wr_q;
  cal_time_t cur_t;
  cal_time_t shown_t;

  assign tick_run  = sec_tick && (osc_ctl == OSC_RUN);
  assign upd_start = tick_run && !set_mode;

  cal_time_core #(.BASE_YEAR(BASE_YEAR)) core_i (
    .clk(clk), .rst_n(rst_n), .adv(tick_run),
    .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
    .data_bin(data_bin), .hr24(hr24), .cur(cur_t)
  );

  cal_update_seq #(.UPD_DELAY(UPD_DELAY)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(upd_start), .uip(uip), .done(upd_done)
  );

  cal_alarm_cmp alarm_i (
    .now(cur_t), .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
    .data_bin(data_bin), .hr24(hr24), .hit(alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      shown_t <= CAL_RESET_TIME;
    end else begin
      wr_q <= wr_en;
      if (upd_done || wr_q) shown_t <= cur_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag   <= 1'b0;
      alarm_flag <= 1'b0;
      upd_flag   <= 1'b0;
    end else begin
      if (clr_flags) begin
        irq_flag   <= 1'b0;
        alarm_flag <= 1'b0;
        upd_flag   <= 1'b0;
      end
      if (upd_done) begin
        upd_flag <= 1'b1;
        if (alarm_en && alarm_hit) begin
          alarm_flag <= 1'b1;
          irq_flag   <= 1'b1;
        end
        if (upd_irq_en) irq_flag <= 1'b1;
      end
    end
  end

  assign sec_out  = enc_val(shown_t.sec, data_bin);
  assign min_out  = enc_val(shown_t.min, data_bin);
  assign hr_out   = enc_hour(shown_t.hr, data_bin, hr24);
  assign wday_out = enc_val(shown_t.wday, data_bin);
  assign mday_out = enc_val(shown_t.mday, data_bin);
  assign mon_out  = enc_val(shown_t.mon, data_bin);
  assign year_out = enc_val(shown_t.year, data_bin);

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic [2:0] osc_ctl,
  input logic       set_mode,
  input logic       clr_flags,
  input logic       uip,
  input logic       upd_done,
  input logic       data_bin,
  input logic [7:0] sec_out,
  input logic       irq_flag,
  input logic       alarm_flag,
  input logic       upd_flag
);

  // R3
  uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_tick && (osc_ctl == 3'b010) && !set_mode));

  // R2
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && (osc_ctl != 3'b010) && !uip) |=> !uip);

  // R4
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && set_mode && !uip) |=> !uip);

  // R3
  upd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> $past(upd_done));

  // R10
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> (upd_flag && !uip));

  // R9
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> irq_flag);

  // R11
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !upd_done) |=> (!upd_flag && !alarm_flag && !irq_flag));

  // R5
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_bin |-> (sec_out[3:0] <= 4'd9));

endmodule

bind cal_clock cal_clock_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
  .set_mode(set_mode), .clr_flags(clr_flags), .uip(uip), .upd_done(upd_done),
  .data_bin(data_bin), .sec_out(sec_out), .irq_flag(irq_flag),
  .alarm_flag(alarm_flag), .upd_flag(upd_flag)
);

// File: tb/cal_clock_tb_top.sv
module cal_clock_tb_top;

  localparam int CLK_P = 10;
  localparam int DLY   = 8;
  localparam int BASE  = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [2:0] osc_ctl = 3'b010;
  logic       set_mode = 1'b0;
  logic       data_bin = 1'b0;
  logic       hr24 = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_field = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       alarm_en = 1'b0;
  logic       upd_irq_en = 1'b0;
  logic [7:0] al_sec = 8'hC0, al_min = 8'hC0, al_hr = 8'hC0;
  logic       clr_flags = 1'b0;
  logic       uip, irq_flag, alarm_flag, upd_flag;
  logic [7:0] sec_out, min_out, hr_out, wday_out, mday_out, mon_out, year_out;

  int checks = 0;
  int errors = 0;

  // bench model: internal time m_*, shown snapshot s_*
  int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;
  int s_s, s_mi, s_h, s_w, s_d, s_mo, s_y;

  always #(CLK_P/2) clk = ~clk;

  cal_clock dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
    .set_mode(set_mode), .data_bin(data_bin), .hr24(hr24), .wr_en(wr_en),
    .wr_field(wr_field), .wr_data(wr_data), .alarm_en(alarm_en),
    .upd_irq_en(upd_irq_en), .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
    .clr_flags(clr_flags), .uip(uip), .sec_out(sec_out), .min_out(min_out),
    .hr_out(hr_out), .wday_out(wday_out), .mday_out(mday_out),
    .mon_out(mon_out), .year_out(year_out), .irq_flag(irq_flag),
    .alarm_flag(alarm_flag), .upd_flag(upd_flag)
  );

  function automatic logic [7:0] b_enc(int v);
    return data_bin ? 8'(v) : 8'(v + 6 * (v / 10));
  endfunction

  function automatic logic [7:0] b_enc_hr(int h);
    int h12;
    if (hr24) return b_enc(h);
    h12 = ((h + 11) % 12) + 1;
    return b_enc(h12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int b_dim(int mo, int yy);
    int full;
    full = BASE + yy;
    if (mo == 2) return ((full % 400 == 0) || (full % 4 == 0 && full % 100 != 0)) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_advance();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_w = (m_w % 7) + 1;
    m_d++;
    if (m_d <= b_dim(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1;
    m_y = (m_y + 1) % 100;
  endtask

  task automatic snap();
    s_s = m_s; s_mi = m_mi; s_h = m_h; s_w = m_w; s_d = m_d; s_mo = m_mo; s_y = m_y;
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(string req);
    chk(req, "sec",  sec_out,  b_enc(s_s));
    chk(req, "min",  min_out,  b_enc(s_mi));
    chk(req, "hour", hr_out,   b_enc_hr(s_h));
    chk(req, "wday", wday_out, b_enc(s_w));
    chk(req, "mday", mday_out, b_enc(s_d));
    chk(req, "mon",  mon_out,  b_enc(s_mo));
    chk(req, "year", year_out, b_enc(s_y));
  endtask

  task automatic write_field(int f, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_field = 3'(f); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(int s, int mi, int h, int w, int d, int mo, int y);
    write_field(0, b_enc(s));
    write_field(1, b_enc(mi));
    write_field(2, b_enc_hr(h));
    write_field(3, b_enc(w));
    write_field(4, b_enc(d));
    write_field(5, b_enc(mo));
    write_field(6, b_enc(y));
    m_s = s; m_mi = mi; m_h = h; m_w = w; m_d = d; m_mo = mo; m_y = y;
    snap();
  endtask

  task automatic clr_pulse();
    @(negedge clk); clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
  endtask

  // One tick; checks uip during and after the window, updates the model.
  task automatic do_tick(string req);
    logic run;
    run = (osc_ctl == 3'b010);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R3", {req, " uip open"}, {7'd0, uip}, {7'd0, run && !set_mode});
    repeat (DLY - 1) @(negedge clk);
    chk("R3", {req, " uip late"}, {7'd0, uip}, {7'd0, run && !set_mode});
    @(negedge clk);
    chk("R3", {req, " uip closed"}, {7'd0, uip}, 8'd0);
    if (run) model_advance();
    if (run && !set_mode) snap();
  endtask

  task automatic chk_flags(string req, logic u, logic a, logic i);
    chk(req, "upd_flag",   {7'd0, upd_flag},   {7'd0, u});
    chk(req, "alarm_flag", {7'd0, alarm_flag}, {7'd0, a});
    chk(req, "irq_flag",   {7'd0, irq_flag},   {7'd0, i});
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 0;
    snap();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_fields("R1");
    chk("R1", "uip", {7'd0, uip}, 8'd0);
    chk_flags("R1", 1'b0, 1'b0, 1'b0);

    // R12 write then read back; R3 plain tick; R10 upd flag without irq
    set_time(58, 30, 13, 3, 15, 6, 24);
    chk_fields("R12");
    do_tick("R3");
    chk_fields("R3");
    chk_flags("R10", 1'b1, 1'b0, 1'b0);

    // R10 with update interrupt enabled
    clr_pulse();
    chk_flags("R11", 1'b0, 1'b0, 1'b0);
    upd_irq_en = 1'b1;
    do_tick("R10");
    chk_flags("R10", 1'b1, 1'b0, 1'b1);
    upd_irq_en = 1'b0;

    // R2 oscillator gate
    clr_pulse();
    osc_ctl = 3'b011;
    do_tick("R2");
    chk_fields("R2");
    chk_flags("R2", 1'b0, 1'b0, 1'b0);
    osc_ctl = 3'b010;

    // R4 set mode: internal advance, nothing shown
    set_mode = 1'b1;
    do_tick("R4");
    chk_fields("R4");
    chk_flags("R4", 1'b0, 1'b0, 1'b0);
    set_mode = 1'b0;
    do_tick("R4");
    chk_fields("R4");

    // R7 full rollover incl. year 99 -> 00 and weekday 7 -> 1
    set_time(59, 59, 23, 7, 31, 12, 99);
    do_tick("R7");
    chk_fields("R7");
    chk("R7", "year wrap", year_out, 8'h00);
    chk("R7", "wday wrap", wday_out, 8'h01);

    // R8 month lengths and leap rule
    set_time(59, 59, 23, 1, 28, 2, 0);
    do_tick("R8");
    chk("R8", "2000 feb 29", mday_out, 8'h29);
    set_time(59, 59, 23, 1, 28, 2, 1);
    do_tick("R8");
    chk("R8", "2001 mar 1", mon_out, 8'h03);
    set_time(59, 59, 23, 1, 29, 2, 4);
    do_tick("R8");
    chk("R8", "2004 mar 1", mon_out, 8'h03);
    set_time(59, 59, 23, 1, 30, 4, 10);
    do_tick("R8");
    chk_fields("R8");
    chk("R8", "apr 30 end", mon_out, 8'h05);

    // R6 12-hour midnight and noon
    hr24 = 1'b0;
    set_time(59, 59, 23, 2, 10, 3, 5);
    do_tick("R6");
    chk("R6", "midnight", hr_out, 8'h12);
    set_time(59, 59, 11, 2, 10, 3, 5);
    do_tick("R6");
    chk("R6", "noon", hr_out, 8'h92);
    data_bin = 1'b1;
    @(negedge clk);
    chk("R6", "noon binary", hr_out, 8'h8C);
    // R5 re-encode without tick
    chk("R5", "binary sec", sec_out, 8'd0);
    chk_fields("R5");
    data_bin = 1'b0; hr24 = 1'b1;
    @(negedge clk);
    chk("R5", "bcd hour", hr_out, 8'h12);

    // R9 exact alarm, don't care, mismatch, disabled
    set_time(9, 45, 17, 4, 20, 8, 33);
    clr_pulse();
    alarm_en = 1'b1;
    al_sec = 8'h10; al_min = 8'h45; al_hr = 8'h17;
    do_tick("R9");
    chk_flags("R9", 1'b1, 1'b1, 1'b1);
    clr_pulse();
    al_sec = 8'hC0; al_min = 8'hFF; al_hr = 8'hC3;
    do_tick("R9");
    chk_flags("R9", 1'b1, 1'b1, 1'b1);
    clr_pulse();
    al_sec = 8'h00; al_min = 8'hC0; al_hr = 8'hC0;
    do_tick("R9");
    chk_flags("R9", 1'b1, 1'b0, 1'b0);
    clr_pulse();
    alarm_en = 1'b0;
    al_sec = 8'hC0;
    do_tick("R9");
    chk_flags("R9", 1'b1, 1'b0, 1'b0);

    // R11 clear in the same cycle as update end: set wins
    clr_pulse();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (DLY - 1) @(negedge clk);
    clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    model_advance(); snap();
    chk_flags("R11", 1'b1, 1'b0, 1'b0);
    chk_fields("R11");

    // Random mix: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 150; i++) begin
      int mo, yy, ns, nmi, nh, sel;
      logic hs, hm, hh;
      data_bin   = 1'($urandom);
      hr24       = 1'($urandom);
      alarm_en   = 1'($urandom);
      upd_irq_en = 1'($urandom);
      mo = 1 + int'($urandom % 12);
      yy = int'($urandom % 100);
      set_time(int'($urandom % 60), int'($urandom % 60), int'($urandom % 24),
               1 + int'($urandom % 7), 1 + int'($urandom % b_dim(mo, yy)), mo, yy);
      if ($urandom % 4 == 0) begin m_s = 59; write_field(0, b_enc(59)); end
      if ($urandom % 6 == 0) begin m_mi = 59; write_field(1, b_enc(59)); end
      snap();
      ns = (m_s + 1) % 60;
      nmi = (m_s == 59) ? (m_mi + 1) % 60 : m_mi;
      nh = (m_s == 59 && m_mi == 59) ? (m_h + 1) % 24 : m_h;
      sel = int'($urandom % 3);
      hs = (sel != 2); al_sec = (sel == 0) ? (8'hC0 | 8'($urandom % 64)) : b_enc((sel == 1) ? ns : (ns + 7) % 60);
      sel = int'($urandom % 3);
      hm = (sel != 2); al_min = (sel == 0) ? 8'hC0 : b_enc((sel == 1) ? nmi : (nmi + 3) % 60);
      sel = int'($urandom % 3);
      hh = (sel != 2); al_hr = (sel == 0) ? 8'hC0 : b_enc_hr((sel == 1) ? nh : (nh + 5) % 24);
      clr_pulse();
      do_tick("R7");
      chk_fields("R7");
      chk_flags("R9", 1'b1, alarm_en && hs && hm && hh,
                upd_irq_en || (alarm_en && hs && hm && hh));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule